// File: doc/BRIEF.md
# Staggered Multichannel Grayscale PWM Engine

This block turns a bank of per-channel brightness codes into pulse-width modulated enable signals. All channels share one up-counter clocked by the grayscale clock. Each channel compares that counter against its own latched brightness code. A channel is on while the counter is below the code, which gives 4096 duty steps for a 12-bit code.

The counter runs through one frame of 4096 counts and then parks. The outputs stay off after that until the blank input restarts the frame. While blank is high, every output is forced off at once, the counter is cleared, and the latch takes the brightness bus. Changes on the bus while blank is low have no effect until the next blank. The turn-on edges are spread out to avoid switching every channel at the same instant: channel n reaches its output n grayscale clock periods after channel 0.

Top module: `gs_pwm_engine`

## Requirements
- R1: While rst is high, and after it, every output is low and every latched brightness code is zero. With blank low after reset, no channel turns on until a blank pulse loads new codes.
- R2: In any cycle where blank is high, every bit of ch_on is low in that same cycle, without waiting for a clock edge.
- R3: The shared counter restarts from zero whenever blank is high. A channel 0 with a nonzero code is high in the first cycle after the first rising edge that samples blank low.
- R4: Take E1 as the first edge that samples blank low and k as its 1-based index of later edges. Channel 0 is high after edge Ek exactly when 1 <= k <= v0, where v0 is its latched code. Counter value k-1 is compared as "count < code".
- R5: A code of 0 keeps its channel low for the whole frame. A code of 4095 keeps its channel high for 4095 consecutive cycles.
- R6: Once the counter has compared value 4095, it stops and every output stays low until blank is raised again.
- R7: Channel n shows the same on-window as R4, using its own code vn, shifted later by n cycles: it is high after edge Ek exactly when n+1 <= k <= vn+n.
- R8: Codes are captured from level_bus on each rising edge that samples blank high. Bus changes while blank is low do not alter the current frame.
- R9: The code for channel n is the 12-bit field level_bus[n*12 +: 12], with bit 0 of the field as its least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gsclk | input | 1 | Grayscale clock; every register in the block uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| blank | input | 1 | Forces outputs off, clears the counter and loads brightness codes |
| level_bus | input | NUM_CH*GS_W (192) | Packed brightness codes, channel n at bits n*12 +: 12 |
| ch_on | output | NUM_CH (16) | Active-high enable per channel |

## Verification
The assertions assume that blank and level_bus are synchronous to gsclk and settle between edges. They also assume that reset is applied before blank is used, so that the counter and phase start from a known state. The bench drives every input a short time after the rising edge and changes the bus only after a full edge has sampled blank. Its frames are long enough, about 4200 cycles, to pass the end-of-frame hold point before the next blank pulse.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

    localparam int CH_COUNT   = 16;
    localparam int LEVEL_BITS = 12;

    // Frame phase of the shared counter.
    typedef enum logic [1:0] {
        PH_BLANKED = 2'd0,
        PH_RUN     = 2'd1,
        PH_DONE    = 2'd2
    } phase_e;

    // A channel is lit when the frame is still live and count is below its code.
    function automatic logic lit(input phase_e ph, input logic [31:0] cnt,
                                 input logic [31:0] code);
        return (ph != PH_DONE) && (cnt < code);
    endfunction

endpackage

// File: rtl/gs_counter.sv
module gs_counter
    import gs_pwm_pkg::*;
#(
    parameter int GS_W = LEVEL_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            blank,
    output logic [GS_W-1:0] cnt,
    output phase_e          phase
);
    localparam logic [GS_W-1:0] CNT_TOP = {GS_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || blank) begin
            cnt   <= '0;
            phase <= PH_BLANKED;
        end else begin
            case (phase)
                PH_DONE: begin
                    cnt   <= cnt;
                    phase <= PH_DONE;
                end
                default: begin
                    if (cnt == CNT_TOP) begin
                        phase <= PH_DONE;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        phase <= PH_RUN;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/gs_level_latch.sv
module gs_level_latch
    import gs_pwm_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int GS_W   = LEVEL_BITS
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             blank,
    input  logic [NUM_CH*GS_W-1:0]           bus,
    output logic [NUM_CH-1:0][GS_W-1:0]      lvl
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl[n] <= '0;
            end else if (blank) begin
                lvl[n] <= bus[n*GS_W +: GS_W];
            end
        end
    end

endmodule

// File: rtl/gs_stagger.sv
module gs_stagger
    import gs_pwm_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int GS_W   = LEVEL_BITS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        blank,
    input  logic [GS_W-1:0]             cnt,
    input  phase_e                      phase,
    input  logic [NUM_CH-1:0][GS_W-1:0] lvl,
    output logic [NUM_CH-1:0]           staged
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic cmp_q;

        always_ff @(posedge clk) begin
            if (rst || blank) begin
                cmp_q <= 1'b0;
            end else begin
                cmp_q <= lit(phase, 32'(cnt), 32'(lvl[n]));
            end
        end

        if (n == 0) begin : g_direct
            assign staged[n] = cmp_q;
        end else begin : g_delay
            logic [n-1:0] dly_q;
            always_ff @(posedge clk) begin
                if (rst || blank) begin
                    dly_q <= '0;
                end else begin
                    dly_q[0] <= cmp_q;
                    for (int k = 1; k < n; k++) begin
                        dly_q[k] <= dly_q[k-1];
                    end
                end
            end
            assign staged[n] = dly_q[n-1];
        end
    end

endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine
    import gs_pwm_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int GS_W   = LEVEL_BITS
) (
    input  logic                   gsclk,
    input  logic                   rst,
    input  logic                   blank,
    input  logic [NUM_CH*GS_W-1:0] level_bus,
    output logic [NUM_CH-1:0]      ch_on
);
    logic [GS_W-1:0]             cnt_q;
    phase_e                      phase_q;
    logic [NUM_CH-1:0][GS_W-1:0] lvl_q;
    logic [NUM_CH-1:0]           staged;

    gs_counter #(.GS_W(GS_W)) u_cnt (
        .clk   (gsclk),
        .rst   (rst),
        .blank (blank),
        .cnt   (cnt_q),
        .phase (phase_q)
    );

    gs_level_latch #(.NUM_CH(NUM_CH), .GS_W(GS_W)) u_lat (
        .clk   (gsclk),
        .rst   (rst),
        .blank (blank),
        .bus   (level_bus),
        .lvl   (lvl_q)
    );

    gs_stagger #(.NUM_CH(NUM_CH), .GS_W(GS_W)) u_stg (
        .clk    (gsclk),
        .rst    (rst),
        .blank  (blank),
        .cnt    (cnt_q),
        .phase  (phase_q),
        .lvl    (lvl_q),
        .staged (staged)
    );

    assign ch_on = staged & {NUM_CH{~blank}};

endmodule

// File: rtl/gs_pwm_checker.sv
module gs_pwm_checker
    import gs_pwm_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int GS_W   = LEVEL_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic              blank,
    input logic [NUM_CH-1:0] ch_on,
    input logic [GS_W-1:0]   cnt,
    input phase_e            phase,
    input logic [GS_W-1:0]   lvl0
);
    localparam logic [GS_W-1:0] CNT_TOP = {GS_W{1'b1}};

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (ch_on == '0) && (phase == PH_BLANKED));

    a_r2_blank_off: assert property (@(posedge clk) disable iff (rst)
        blank |-> (ch_on == '0));

    a_r3_count_restart: assert property (@(posedge clk) disable iff (rst)
        $past(blank) |-> (cnt == '0));

    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (!blank && phase != PH_DONE && cnt != CNT_TOP) |=> (cnt == $past(cnt) + 1'b1));

    a_r5_zero_dark: assert property (@(posedge clk) disable iff (rst)
        (lvl0 == '0) |-> !ch_on[0]);

    a_r6_hold_end: assert property (@(posedge clk) disable iff (rst)
        (!blank && phase == PH_DONE) |=> (phase == PH_DONE) && $stable(cnt));

    a_r6_end_dark: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE && $past(phase) == PH_DONE) |-> !ch_on[0]);

endmodule

bind gs_pwm_engine gs_pwm_checker #(.NUM_CH(NUM_CH), .GS_W(GS_W)) u_chk (
    .clk   (gsclk),
    .rst   (rst),
    .blank (blank),
    .ch_on (ch_on),
    .cnt   (cnt_q),
    .phase (phase_q),
    .lvl0  (lvl_q[0])
);

// File: tb/gs_pwm_engine_test.sv
module gs_pwm_engine_test;
    localparam int NCH = 16;
    localparam int GW  = 12;
    localparam int TOPV = 4095;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic blank = 1'b0;
    logic [NCH*GW-1:0] bus = '0;
    logic [NCH-1:0] ch_on;

    always #4 clk = ~clk;

    gs_pwm_engine #(.NUM_CH(NCH), .GS_W(GW)) uut (
        .gsclk     (clk),
        .rst       (rst),
        .blank     (blank),
        .level_bus (bus),
        .ch_on     (ch_on)
    );

    int total = 0;
    int bad = 0;
    int t = 0;
    int v [NCH];
    bit moved = 1'b0;

    function automatic logic [NCH*GW-1:0] pat_a();
        logic [NCH*GW-1:0] r;
        for (int n = 0; n < NCH; n++) begin
            int x;
            x = (n * 263 + 7) % 4096;
            if (n == 0) x = TOPV;
            if (n == 1) x = 1;
            if (n == 3) x = 0;
            if (n == 7) x = TOPV;
            r[n*GW +: GW] = GW'(x);
        end
        return r;
    endfunction

    function automatic logic [NCH*GW-1:0] pat_b();
        logic [NCH*GW-1:0] r;
        for (int n = 0; n < NCH; n++) r[n*GW +: GW] = GW'(n * 2 + 3);
        return r;
    endfunction

    function automatic logic [NCH*GW-1:0] pat_c();
        logic [NCH*GW-1:0] r;
        for (int n = 0; n < NCH; n++) r[n*GW +: GW] = (n == 2) ? GW'(0) : GW'(TOPV);
        return r;
    endfunction

    function automatic string tag_for(int n);
        if (rst) return "R1";
        if (blank) return "R2";
        if (moved && (int'(bus[n*GW +: GW]) != v[n])) return "R8";
        if (v[n] == 0 || v[n] == TOPV) return "R5";
        if (t > TOPV + 1) return "R6";
        if (n > 0) return "R7";
        if (t == 1) return "R3";
        return "R4 R9";
    endfunction

    task automatic step();
        logic [NCH-1:0] exp_v;
        @(posedge clk);
        #1;
        if (rst) begin
            t = 0;
            for (int k = 0; k < NCH; k++) v[k] = 0;
            moved = 1'b0;
        end else if (blank) begin
            t = 0;
            for (int k = 0; k < NCH; k++) v[k] = int'(bus[k*GW +: GW]);
            moved = 1'b0;
        end else begin
            t++;
        end
        for (int n = 0; n < NCH; n++)
            exp_v[n] = !blank && (t >= n + 1) && (t <= v[n] + n);
        total++;
        if (ch_on !== exp_v) begin
            bad++;
            for (int n = 0; n < NCH; n++) begin
                if (ch_on[n] !== exp_v[n]) begin
                    $display("FAIL %s ch%0d t=%0d: actual=%b expected=%b (vec actual=%h expected=%h)",
                             tag_for(n), n, t, ch_on[n], exp_v[n], ch_on, exp_v);
                    break;
                end
            end
        end
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    initial begin : watchdog
        #(8 * 60000);
        bad++;
        $display("FAIL R4 watchdog: actual=still running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        // R1: reset with a nonzero bus, then free run without blank
        rst = 1'b1;
        bus = pat_a();
        run(3);
        rst = 1'b0;
        run(30);

        // R4 R5 R7 R9 with pattern A; R8 bus change mid-frame; R6 end hold
        blank = 1'b1;
        run(2);
        blank = 1'b0;
        run(50);
        bus = pat_b();
        moved = 1'b1;
        run(4200);

        // R3 restart with pattern B, R2 mid-frame blank
        blank = 1'b1;
        run(1);
        blank = 1'b0;
        run(40);
        blank = 1'b1;
        run(3);
        blank = 1'b0;
        run(4200);

        // R5 full-scale and zero codes, R6 again
        bus = pat_c();
        blank = 1'b1;
        run(2);
        blank = 1'b0;
        run(4200);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule